// File: doc/BRIEF.md
# Burst-of-Four Double-Rate SRAM Model

This block is a synthesizable behavioural model of a static memory with a separate read port and write port. The two ports share one address bus. Time runs on a single core clock whose cycles stand for half-periods of the memory's input clock. A phase register marks which core edges stand for rising edges of the positive input clock (K rise); the other edges stand for the rising edge of the complementary clock. Every access moves a burst of four data words. The write port takes one word per core edge. The read port drives one word per core edge. Storage is split into four sub-arrays, and the beat number of a word within its burst selects the sub-array.

Each port is requested with an active-low select, and a select counts only on a K-rise edge. A write lands its first word on the edge that accepts it and its other three words on the next three edges. Each word carries its own active-low lane selects. A read captures all four words of the addressed group on the accepting edge. It presents them after a fixed delay of one and a half input-clock periods, then releases the output.

Top module: `qdrb_sram`

## Requirements
- R1: `krise` is high in the first cycle after reset and then alternates every cycle. A select that is low while `krise` is low has no effect.
- R2: A write accepted on an edge stores `d` from that edge into word {addr, 2'b00}. It then stores `d` from each of the next three edges into words {addr, 2'b01}, {addr, 2'b10} and {addr, 2'b11}.
- R3: Each word of a write has its own `lane_n` bits, sampled on the same edge as that word. Bit 0 covers data bits 8:0 and bit 1 covers bits 17:9, and a bit value of 1 leaves the stored lane unchanged.
- R4: While a port's burst is still in its three follow-on edges, a select low on that port's K-rise edge is ignored. The next accept is possible four edges after the previous one.
- R5: While both selects are high, no word changes, whatever `addr`, `d` and `lane_n` carry.
- R6: For a read accepted on edge n, word b of the group (b = 0..3) is on `q`, with `q_oe` high, in the cycle after edge n+3+b.
- R7: A read returns the contents as they were before the accepting edge. A write word landing on that same edge, including a write to the same address that starts on that edge, is not seen by the read.
- R8: Reads accepted four edges apart keep `q_oe` high without a gap between the bursts.
- R9: In every cycle that carries no read word, `q_oe` is low and `q` is zero. The edge after the last word of a burst releases the output unless a new burst follows.
- R10: During and right after reset, `q_oe` is low, `q` is zero, and `krise` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; one cycle per half input-clock period |
| rst_n | input | 1 | Synchronous reset, active low |
| krise | output | 1 | High when the coming edge stands for a K rising edge |
| rd_n | input | 1 | Read port select, active low |
| wr_n | input | 1 | Write port select, active low |
| addr | input | ADDR_W (4) | Shared burst address |
| d | input | LANE_W*LANES (18) | Write data, one word per edge |
| lane_n | input | LANES (2) | Per-word lane write selects, active low |
| q | output | LANE_W*LANES (18) | Read data, one word per edge |
| q_oe | output | 1 | High while `q` carries a read word |

## Verification
A write word lands in the array on the very edge that samples it. It shows up on the ports only through a later read, so every storage check goes through a read. A read word is due in the cycle after the third, fourth, fifth and sixth edges past the accepting edge. The bench keeps a model that files each expected word into a slot keyed by the edge number it is due after. At the falling clock edge after each core edge, the bench compares `q` and `q_oe` against that slot, and an empty slot means the bus must be released. The model applies the writes of each edge only after it has taken the read snapshot for that edge. This gives the read-before-write result for a read and a write that start on the same edge.

// File: rtl/qdrb_pkg.sv
package qdrb_pkg;
  localparam int unsigned BEATS = 4;
  localparam int unsigned RD_LAT = 3;  // core edges from capture to first word

  typedef logic [1:0] beat_t;

  function automatic beat_t beat_next(beat_t b);
    return b + beat_t'(1);
  endfunction

  function automatic logic beat_last(beat_t b);
    return b == beat_t'(BEATS - 1);
  endfunction
endpackage

// File: rtl/qdrb_phase.sv
module qdrb_phase (
  input  logic clk,
  input  logic rst_n,
  output logic krise
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign krise = ~half_q;

  a_r1_krise_then_fall: assert property (@(posedge clk) disable iff (!rst_n)
    krise |=> !krise);
  a_r1_fall_then_krise: assert property (@(posedge clk) disable iff (!rst_n)
    !krise |=> krise);
endmodule

// File: rtl/qdrb_wr_port.sv
module qdrb_wr_port
  import qdrb_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              krise,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              we,
  output logic [ADDR_W+1:0] widx
);
  logic              busy_q;
  beat_t             beat_q;
  logic [ADDR_W-1:0] base_q;
  logic              wr_accept;

  assign wr_accept = krise & ~wr_n & ~busy_q;
  assign we        = wr_accept | busy_q;
  assign widx      = wr_accept ? {addr, beat_t'(0)} : {base_q, beat_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      base_q <= '0;
    end else if (wr_accept) begin
      busy_q <= 1'b1;
      beat_q <= beat_t'(1);
      base_q <= addr;
    end else if (busy_q) begin
      beat_q <= beat_next(beat_q);
      if (beat_last(beat_q)) busy_q <= 1'b0;
    end
  end

  a_r2_wr_span: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (busy_q ##1 busy_q ##1 busy_q ##1 !busy_q));
  a_r4_wr_follow_on: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (widx[1:0] != 2'b00));
endmodule

// File: rtl/qdrb_array.sv
module qdrb_array
  import qdrb_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned WIDTH = LANE_W * LANES,
  localparam int unsigned WORDS = (1 << ADDR_W) * BEATS
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [ADDR_W+1:0]      widx,
  input  logic [WIDTH-1:0]       d,
  input  logic [LANES-1:0]       lane_n,
  input  logic [ADDR_W-1:0]      raddr,
  output logic [BEATS*WIDTH-1:0] snap
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < int'(LANES); l++) begin
        if (!lane_n[l]) mem[widx][l*LANE_W +: LANE_W] <= d[l*LANE_W +: LANE_W];
      end
    end
  end

  for (genvar b = 0; b < int'(BEATS); b++) begin : g_sub
    assign snap[b*WIDTH +: WIDTH] = mem[{raddr, beat_t'(b)}];
  end
endmodule

// File: rtl/qdrb_rd_port.sv
module qdrb_rd_port
  import qdrb_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   krise,
  input  logic                   rd_n,
  input  logic [BEATS*WIDTH-1:0] snap,
  output logic [WIDTH-1:0]       q,
  output logic                   q_oe
);
  logic                   rd_accept;
  logic                   busy_q;
  beat_t                  cap_beat_q;
  logic [RD_LAT-1:0]      lat_q;
  logic [BEATS*WIDTH-1:0] pend_q;
  logic [BEATS*WIDTH-1:0] obuf_q;
  beat_t                  obeat_q;
  logic                   load;

  function automatic logic [WIDTH-1:0] pick(logic [BEATS*WIDTH-1:0] v, beat_t b);
    logic [WIDTH-1:0] r;
    r = '0;
    for (int i = 0; i < int'(BEATS); i++) begin
      if (b == beat_t'(i)) r = v[i*WIDTH +: WIDTH];
    end
    return r;
  endfunction

  assign rd_accept = krise & ~rd_n & ~busy_q;
  assign load      = lat_q[RD_LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cap_beat_q <= '0;
      lat_q      <= '0;
      pend_q     <= '0;
      obuf_q     <= '0;
      obeat_q    <= '0;
      q          <= '0;
      q_oe       <= 1'b0;
    end else begin
      lat_q <= {lat_q[RD_LAT-2:0], rd_accept};
      if (rd_accept) begin
        pend_q     <= snap;
        busy_q     <= 1'b1;
        cap_beat_q <= beat_t'(1);
      end else if (busy_q) begin
        cap_beat_q <= beat_next(cap_beat_q);
        if (beat_last(cap_beat_q)) busy_q <= 1'b0;
      end
      if (load) begin
        q       <= pick(pend_q, beat_t'(0));
        obuf_q  <= pend_q;
        obeat_q <= beat_t'(1);
        q_oe    <= 1'b1;
      end else if (q_oe && obeat_q != beat_t'(0)) begin
        q       <= pick(obuf_q, obeat_q);
        obeat_q <= beat_next(obeat_q);
      end else begin
        q    <= '0;
        q_oe <= 1'b0;
      end
    end
  end

  a_r6_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |-> ##4 q_oe);
  a_r8_four_words: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_oe) |-> ##3 q_oe);
  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !q_oe |-> (q == '0));
  a_r4_rd_span: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> (busy_q ##1 busy_q ##1 busy_q ##1 !busy_q));
endmodule

// File: rtl/qdrb_sram.sv
module qdrb_sram
  import qdrb_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned WIDTH  = LANE_W * LANES,
  localparam int unsigned ADDR_W = $clog2(DEPTH / BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              krise,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  d,
  input  logic [LANES-1:0]  lane_n,
  output logic [WIDTH-1:0]  q,
  output logic              q_oe
);
  logic                   we;
  logic [ADDR_W+1:0]      widx;
  logic [BEATS*WIDTH-1:0] snap;

  qdrb_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .krise (krise)
  );

  qdrb_wr_port #(.ADDR_W(ADDR_W)) u_wr (
    .clk   (clk),
    .rst_n (rst_n),
    .krise (krise),
    .wr_n  (wr_n),
    .addr  (addr),
    .we    (we),
    .widx  (widx)
  );

  qdrb_array #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_array (
    .clk    (clk),
    .we     (we),
    .widx   (widx),
    .d      (d),
    .lane_n (lane_n),
    .raddr  (addr),
    .snap   (snap)
  );

  qdrb_rd_port #(.WIDTH(WIDTH)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .krise (krise),
    .rd_n  (rd_n),
    .snap  (snap),
    .q     (q),
    .q_oe  (q_oe)
  );
endmodule

// File: tb/qdrb_sram_bench.sv
module qdrb_sram_bench;
  localparam int LW = 9;
  localparam int L  = 2;
  localparam int W  = LW * L;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH / 4);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          krise;
  logic          rd_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  d = '0;
  logic [L-1:0]  lane_n = '1;
  logic [W-1:0]  q;
  logic          q_oe;

  always #4 clk = ~clk;

  qdrb_sram #(.LANE_W(LW), .LANES(L), .DEPTH(DEPTH)) u_qdrb_sram (
    .clk(clk), .rst_n(rst_n), .krise(krise), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .d(d), .lane_n(lane_n), .q(q), .q_oe(q_oe)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [W-1:0]  ref_mem [DEPTH];
  logic [W-1:0]  exp_q  [16];
  logic          exp_oe [16];
  string         exp_tag[16];
  int            edge_n = 0;
  logic          b_kr = 1'b1;
  logic          b_wbusy = 1'b0;
  int            b_wbeat = 0;
  logic [AW-1:0] b_wbase = '0;
  logic          b_rbusy = 1'b0;
  int            b_rbeat = 0;
  string         cur_req = "R2";

  function automatic logic [W-1:0] lane_merge(logic [W-1:0] old, logic [W-1:0] nv,
                                              logic [L-1:0] ln);
    logic [W-1:0] r = old;
    for (int i = 0; i < L; i++) if (ln[i] == 1'b0) r[i*LW +: LW] = nv[i*LW +: LW];
    return r;
  endfunction

  function automatic logic [W-1:0] pat(int a, int b);
    return W'((a * 37 + b * 11 + 5) * 2731);
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one core edge: drive at the falling edge, model the coming edge, check after it
  task automatic step(logic rn, logic wn, logic [AW-1:0] a, logic [W-1:0] dv, logic [L-1:0] ln);
    int e;
    int idx;
    logic r_acc;
    logic w_acc;
    rd_n = rn; wr_n = wn; addr = a; d = dv; lane_n = ln;
    check("R1", W'(krise), W'(b_kr));
    e = edge_n + 1;
    r_acc = b_kr && !rn && !b_rbusy;
    w_acc = b_kr && !wn && !b_wbusy;
    if (r_acc) begin
      for (int b = 0; b < 4; b++) begin
        exp_q[(e + 3 + b) % 16]   = ref_mem[{a, 2'(b)}];
        exp_oe[(e + 3 + b) % 16]  = 1'b1;
        exp_tag[(e + 3 + b) % 16] = cur_req;
      end
      b_rbusy = 1'b1; b_rbeat = 1;
    end else if (b_rbusy) begin
      if (b_rbeat == 3) b_rbusy = 1'b0;
      b_rbeat++;
    end
    if (w_acc || b_wbusy) begin
      idx = w_acc ? int'({a, 2'b00}) : int'({b_wbase, 2'(b_wbeat)});
      ref_mem[idx] = lane_merge(ref_mem[idx], dv, ln);
    end
    if (w_acc) begin
      b_wbusy = 1'b1; b_wbeat = 1; b_wbase = a;
    end else if (b_wbusy) begin
      if (b_wbeat == 3) b_wbusy = 1'b0;
      b_wbeat++;
    end
    b_kr = ~b_kr;
    @(posedge clk);
    edge_n = e;
    @(negedge clk);
    if (exp_oe[e % 16]) begin
      check(exp_tag[e % 16], W'(q_oe), W'(1));
      check(exp_tag[e % 16], q, exp_q[e % 16]);
    end else begin
      check("R9", W'(q_oe), W'(0));
      check("R9", q, '0);
    end
    exp_oe[e % 16] = 1'b0;
  endtask

  task automatic idle();
    step(1'b1, 1'b1, AW'($urandom), W'($urandom), L'($urandom));
  endtask

  task automatic align();
    if (!b_kr) idle();
  endtask

  task automatic write_burst(int a, logic [L-1:0] m0, logic [L-1:0] m1,
                             logic [L-1:0] m2, logic [L-1:0] m3, int salt);
    logic [L-1:0] m[4];
    m[0] = m0; m[1] = m1; m[2] = m2; m[3] = m3;
    align();
    for (int b = 0; b < 4; b++)
      step(1'b1, b == 0 ? 1'b0 : 1'b1, AW'(a), pat(a + salt, b), m[b]);
  endtask

  task automatic read_burst(int a);
    align();
    step(1'b0, 1'b1, AW'(a), W'($urandom), '1);
    for (int b = 0; b < 3; b++) idle();
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) idle();
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) exp_oe[i] = 1'b0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R10", W'(q_oe), W'(0));
    check("R10", q, '0);
    rst_n = 1'b1;
    check("R10", W'(krise), W'(1));

    // R2: fill the whole array with full-lane bursts
    cur_req = "R2";
    for (int a = 0; a < (1 << AW); a++) write_burst(a, '0, '0, '0, '0, 0);
    drain();
    // R6: single read latency
    cur_req = "R6";
    read_burst(2);
    drain();
    // R8: back-to-back reads
    cur_req = "R8";
    for (int a = 0; a < (1 << AW); a++) read_burst(a);
    drain();
    // R3: per-word lane selects
    cur_req = "R3";
    write_burst(5, 2'b10, 2'b01, 2'b11, 2'b00, 100);
    read_burst(5);
    drain();
    // R1: selects on non-K-rise edges
    cur_req = "R1";
    align();
    idle();
    step(1'b1, 1'b0, AW'(6), W'($urandom), '0);
    idle();
    step(1'b0, 1'b1, AW'(6), W'($urandom), '1);
    drain();
    read_burst(6);
    drain();
    // R4: select during a burst is ignored
    cur_req = "R4";
    align();
    step(1'b1, 1'b0, AW'(3), W'($urandom), '0);
    step(1'b1, 1'b1, AW'(3), W'($urandom), '0);
    step(1'b0, 1'b0, AW'(4), W'($urandom), '0);
    step(1'b0, 1'b1, AW'(4), W'($urandom), '0);
    drain();
    read_burst(3);
    read_burst(4);
    drain();
    // R7: read and write to one address on the same edge
    cur_req = "R7";
    align();
    step(1'b0, 1'b0, AW'(7), W'(18'h2AAAA), '0);
    for (int b = 0; b < 3; b++) step(1'b1, 1'b1, AW'(7), W'(18'h15555), '0);
    drain();
    read_burst(7);
    drain();
    // R5: deselected cycles with busy address/data/lanes
    cur_req = "R5";
    for (int i = 0; i < 40; i++) idle();
    for (int a = 0; a < (1 << AW); a++) read_burst(a);
    drain();
    // random mix
    cur_req = "R2";
    for (int i = 0; i < 600; i++)
      step(($urandom % 3) != 0, ($urandom % 3) != 0, AW'($urandom), W'($urandom), L'($urandom));
    drain();
    cur_req = "R6";
    for (int a = 0; a < (1 << AW); a++) read_burst(a);
    drain();

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule